// File: doc/BRIEF.md
# External Bus Data Alignment Controller

This block sits between an internal bus master and a 16-bit external data bus. The master issues one transfer at a time: a byte, a 16-bit word or a 32-bit longword, with an address, a direction and a flag that marks the target area as an 8-bit or a 16-bit device space. The controller breaks the transfer into one, two or four external bus cycles. It places each byte on the upper lane (bits 15..8) or the lower lane (bits 7..0) of the external bus. Write data is driven onto the active lanes. Read data from the lanes is collected into one right-justified internal word.

Multi-byte data is big-endian. The most significant byte sits at the lowest address and moves in the first external cycle. Each external access takes exactly one clock; wait states are not modelled. Word and longword requests at an odd address are rejected and start no bus activity. The size code 2'b11 is reserved and is handled as a longword.

Top module: `ext_bus_aligner`

## Requirements
- R1: Size codes are 2'b00 byte, 2'b01 word, 2'b10 longword. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low in every cycle where `bus_cyc` is high, and high again in the cycle that follows the last bus cycle.
- R2: With `req_narrow`=1 (8-bit space), every bus cycle has `bus_ub`=1 and `bus_lb`=0. The byte being moved is on `bus_dout[15:8]`, and `bus_dout[7:0]`=0.
- R3: With `req_narrow`=1, a byte transfer takes 1 bus cycle, a word takes 2 and a longword takes 4. These cycles run in consecutive clocks, and `bus_addr` increases by 1 from one cycle to the next, starting at `req_addr`.
- R4: With `req_narrow`=0 (16-bit space), a byte transfer takes one cycle at `req_addr`. An even address uses the upper lane only (`bus_ub`=1, `bus_lb`=0). An odd address uses the lower lane only (`bus_ub`=0, `bus_lb`=1).
- R5: With `req_narrow`=0, a word takes one cycle and a longword takes two. Each of these cycles has both strobes high, and `bus_addr` increases by 2 between the two longword cycles.
- R6: On writes, the bytes of `req_wdata` go out most significant first. A byte transfer takes `req_wdata[7:0]`, a word takes `[15:0]` and a longword takes `[31:0]`. In a word cycle, the lower-addressed byte is on `bus_dout[15:8]`. For a byte on the lower lane, the data is on `bus_dout[7:0]`.
- R7: On reads, each cycle samples `bus_din` on the active lanes. `rdata` holds the bytes with the first-read byte most significant, right-justified and zero-extended, and is valid while `done` is high.
- R8: A word or longword request with `req_addr[0]`=1 raises `align_err` for exactly the next clock. No bus cycle runs and `done` is not raised.
- R9: `done` is high for exactly one clock, in the clock right after the final bus cycle of an accepted transfer.
- R10: When `bus_cyc` is low, `bus_ub`, `bus_lb` and `bus_dout` are all zero. `bus_dout` is also zero during read cycles, and `bus_we` follows the request direction only while `bus_cyc` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Transfer request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_addr | input | AW | Byte address of the transfer |
| req_size | input | 2 | Transfer size code |
| req_we | input | 1 | 1 = write, 0 = read |
| req_narrow | input | 1 | 1 = 8-bit device space, 0 = 16-bit space |
| req_wdata | input | 32 | Write data, right-justified |
| align_err | output | 1 | Misaligned request rejected |
| done | output | 1 | Transfer complete pulse |
| rdata | output | 32 | Assembled read data |
| bus_cyc | output | 1 | External access in this clock |
| bus_addr | output | AW | External byte address |
| bus_we | output | 1 | External access is a write |
| bus_ub | output | 1 | Upper lane strobe |
| bus_lb | output | 1 | Lower lane strobe |
| bus_dout | output | 16 | Write data on both lanes |
| bus_din | input | 16 | Read data from both lanes |

## Verification
The bench builds the controller with AW=16. This small address space lets a directed longword at 16'hFFFE, and random addresses near the top, carry the per-cycle address step through wrap-around to zero. The bench models the external device as a fixed function of address: the upper lane returns the even byte and the lower lane the odd byte in 16-bit space, and the upper lane alone serves 8-bit space. As a result, every read has a known assembled value, and a byte placed on the wrong lane or in the wrong order is exposed.

// File: rtl/ebus_align_pkg.sv
// Shared size codes and beat arithmetic for the external bus aligner.
// Assumes a 16-bit external bus and a 32-bit internal data word.
package ebus_align_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_WORD = 2'b01,
        SZ_LONG = 2'b10,
        SZ_RSVD = 2'b11
    } xfer_size_e;

    localparam int unsigned INT_DW = 32;
    localparam int unsigned EXT_DW = 16;

    // Number of external cycles a transfer needs in the given space.
    function automatic logic [2:0] beat_count(input logic [1:0] sz, input logic narrow);
        case (sz)
            SZ_BYTE: beat_count = 3'd1;
            SZ_WORD: beat_count = narrow ? 3'd2 : 3'd1;
            default: beat_count = narrow ? 3'd4 : 3'd2;
        endcase
    endfunction

    // Left-justify write data so the first byte to send is in bits 31..24.
    function automatic logic [INT_DW-1:0] left_justify(input logic [1:0] sz,
                                                       input logic [INT_DW-1:0] d);
        case (sz)
            SZ_BYTE: left_justify = {d[7:0], 24'h0};
            SZ_WORD: left_justify = {d[15:0], 16'h0};
            default: left_justify = d;
        endcase
    endfunction

endpackage

// File: rtl/ebus_seq.sv
// Beat sequencer: accepts a request, rejects misaligned ones, counts the
// external cycles, steps the address and picks the active lane strobes.
// Assumes one clock per external access (no wait states).
module ebus_seq
    import ebus_align_pkg::*;
#(
    parameter int unsigned AW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic [1:0]    req_size,
    input  logic          req_narrow,
    output logic          req_ready,
    output logic          load,
    output logic          busy,
    output logic          align_err,
    output logic          done,
    output logic [AW-1:0] bus_addr,
    output logic          lane_up,
    output logic          lane_lo
);

    logic [2:0]    left_q;
    logic [AW-1:0] addr_q;
    logic          word_q;
    logic          narrow_q;
    logic          misaligned;
    logic          take;

    // Request decode: a multi-byte size at an odd address is rejected.
    always_comb begin
        misaligned = (req_size != SZ_BYTE) && req_addr[0];
        take       = req_valid && !busy;
        load       = take && !misaligned;
    end

    // Sequencer state: busy flag, beats left, address, mode, pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            left_q    <= 3'd0;
            addr_q    <= '0;
            word_q    <= 1'b0;
            narrow_q  <= 1'b0;
            done      <= 1'b0;
            align_err <= 1'b0;
        end else begin
            done      <= busy && (left_q == 3'd1);
            align_err <= take && misaligned;
            if (load) begin
                busy     <= 1'b1;
                left_q   <= beat_count(req_size, req_narrow);
                addr_q   <= req_addr;
                word_q   <= !req_narrow && (req_size != SZ_BYTE);
                narrow_q <= req_narrow;
            end else if (busy) begin
                left_q <= left_q - 3'd1;
                addr_q <= addr_q + (word_q ? AW'(2) : AW'(1));
                if (left_q == 3'd1) begin
                    busy <= 1'b0;
                end
            end
        end
    end

    // Lane selection: 8-bit space stays on the upper lane, bytes follow addr[0].
    always_comb begin
        req_ready = !busy;
        bus_addr  = busy ? addr_q : '0;
        lane_up   = busy && (word_q || narrow_q || !addr_q[0]);
        lane_lo   = busy && (word_q || (!narrow_q && addr_q[0]));
    end

endmodule

// File: rtl/ebus_lane_steer.sv
// Data path: shifts write bytes out most significant first onto the active
// lane(s) and shifts read bytes in to build a right-justified result.
// Assumes the sequencer's lane strobes mark exactly the bytes of each beat.
module ebus_lane_steer
    import ebus_align_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              busy,
    input  logic [1:0]        req_size,
    input  logic              req_we,
    input  logic [INT_DW-1:0] req_wdata,
    input  logic              lane_up,
    input  logic              lane_lo,
    input  logic [EXT_DW-1:0] bus_din,
    output logic              bus_we,
    output logic [EXT_DW-1:0] bus_dout,
    output logic [INT_DW-1:0] rdata
);

    logic [INT_DW-1:0] wsh_q;
    logic [INT_DW-1:0] acc_q;
    logic              we_q;
    logic              word_beat;

    assign word_beat = lane_up && lane_lo;

    // Write shifter and read accumulator, advanced once per beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wsh_q <= '0;
            acc_q <= '0;
            we_q  <= 1'b0;
        end else if (load) begin
            wsh_q <= left_justify(req_size, req_wdata);
            acc_q <= '0;
            we_q  <= req_we;
        end else if (busy) begin
            wsh_q <= word_beat ? {wsh_q[15:0], 16'h0} : {wsh_q[23:0], 8'h0};
            if (!we_q) begin
                acc_q <= word_beat ? {acc_q[15:0], bus_din}
                                   : {acc_q[23:0], (lane_up ? bus_din[15:8] : bus_din[7:0])};
            end
        end
    end

    // Lane drive: only strobed lanes carry data, and only on writes.
    always_comb begin
        bus_we   = busy && we_q;
        bus_dout = '0;
        if (bus_we) begin
            if (word_beat)    bus_dout = wsh_q[31:16];
            else if (lane_up) bus_dout = {wsh_q[31:24], 8'h0};
            else              bus_dout = {8'h0, wsh_q[31:24]};
        end
        rdata = acc_q;
    end

endmodule

// File: rtl/ext_bus_aligner.sv
// Top level: splits byte/word/longword requests into 8- or 16-bit external
// cycles and steers each byte to the upper or lower lane.
// Assumes one outstanding request and single-clock external accesses.
module ext_bus_aligner
    import ebus_align_pkg::*;
#(
    parameter int unsigned AW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_addr,
    input  logic [1:0]    req_size,
    input  logic          req_we,
    input  logic          req_narrow,
    input  logic [31:0]   req_wdata,
    output logic          align_err,
    output logic          done,
    output logic [31:0]   rdata,
    output logic          bus_cyc,
    output logic [AW-1:0] bus_addr,
    output logic          bus_we,
    output logic          bus_ub,
    output logic          bus_lb,
    output logic [15:0]   bus_dout,
    input  logic [15:0]   bus_din
);

    logic load;
    logic busy;
    logic lane_up;
    logic lane_lo;

    ebus_seq #(.AW(AW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .req_size   (req_size),
        .req_narrow (req_narrow),
        .req_ready  (req_ready),
        .load       (load),
        .busy       (busy),
        .align_err  (align_err),
        .done       (done),
        .bus_addr   (bus_addr),
        .lane_up    (lane_up),
        .lane_lo    (lane_lo)
    );

    ebus_lane_steer u_steer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .busy      (busy),
        .req_size  (req_size),
        .req_we    (req_we),
        .req_wdata (req_wdata),
        .lane_up   (lane_up),
        .lane_lo   (lane_lo),
        .bus_din   (bus_din),
        .bus_we    (bus_we),
        .bus_dout  (bus_dout),
        .rdata     (rdata)
    );

    // Port mapping of sequencer state onto the external strobes.
    always_comb begin
        bus_cyc = busy;
        bus_ub  = lane_up;
        bus_lb  = lane_lo;
    end

endmodule

// File: rtl/ebus_align_checker.sv
// Protocol checker for ext_bus_aligner, attached by bind below.
// Assumes it sees only the top-level ports.
module ebus_align_checker #(
    parameter int unsigned AW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic [AW-1:0] req_addr,
    input logic [1:0]    req_size,
    input logic          req_we,
    input logic          req_narrow,
    input logic [31:0]   req_wdata,
    input logic          align_err,
    input logic          done,
    input logic [31:0]   rdata,
    input logic          bus_cyc,
    input logic [AW-1:0] bus_addr,
    input logic          bus_we,
    input logic          bus_ub,
    input logic          bus_lb,
    input logic [15:0]   bus_dout,
    input logic [15:0]   bus_din
);

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cyc |-> !req_ready); // R1

    AST_CYCLE_HAS_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cyc |-> (bus_ub || bus_lb)); // R2

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && $past(bus_cyc)) |->
        (bus_addr == $past(bus_addr) + (($past(bus_ub) && $past(bus_lb)) ? AW'(2) : AW'(1)))); // R3

    AST_LOWER_ONLY_ODD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && bus_lb && !bus_ub) |-> bus_addr[0]); // R4

    AST_WORD_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && bus_lb && bus_ub) |-> !bus_addr[0]); // R5

    AST_MISALIGN_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_size != 2'b00) && req_addr[0]) |=>
        (align_err && !bus_cyc && !done)); // R8

    AST_DONE_AFTER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(bus_cyc) && !bus_cyc)); // R9

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_cyc |-> (!bus_ub && !bus_lb && bus_dout == 16'h0 && !bus_we)); // R10

    AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && !bus_we) |-> (bus_dout == 16'h0)); // R10

endmodule

bind ext_bus_aligner ebus_align_checker #(.AW(AW)) u_chk (.*);

// File: tb/ext_bus_aligner_bench.sv
module ext_bus_aligner_bench;

    localparam int unsigned AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]    req_size = 2'b00;
    logic          req_we = 1'b0;
    logic          req_narrow = 1'b0;
    logic [31:0]   req_wdata = '0;
    logic          align_err;
    logic          done;
    logic [31:0]   rdata;
    logic          bus_cyc;
    logic [AW-1:0] bus_addr;
    logic          bus_we;
    logic          bus_ub;
    logic          bus_lb;
    logic [15:0]   bus_dout;
    logic [15:0]   bus_din;
    logic          cur_narrow = 1'b0;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    ext_bus_aligner #(.AW(AW)) u_ext_bus_aligner (.*);

    // Byte content of the modelled external device at a given address.
    function automatic logic [7:0] mem_byte(input logic [AW-1:0] a);
        return (a[7:0] ^ 8'hA5) + a[15:8] + 8'h13;
    endfunction

    assign bus_din = cur_narrow ? {mem_byte(bus_addr), 8'h00}
                                : {mem_byte({bus_addr[AW-1:1], 1'b0}), mem_byte({bus_addr[AW-1:1], 1'b1})};

    function automatic int nbytes(input logic [1:0] sz);
        return (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
    endfunction

    function automatic logic [7:0] wbyte(input logic [31:0] d, input logic [1:0] sz, input int k);
        return d[8*(nbytes(sz)-1-k) +: 8];
    endfunction

    function automatic logic [31:0] exp_read(input logic [AW-1:0] base, input logic [1:0] sz);
        logic [31:0] v = '0;
        for (int k = 0; k < nbytes(sz); k++) v = (v << 8) | 32'(mem_byte(base + AW'(k)));
        return v;
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One transfer with per-beat checks of lanes, address and data.
    task automatic xfer(input logic [AW-1:0] a, input logic [1:0] sz, input logic we,
                        input logic nar, input logic [31:0] wd);
        int beats;
        logic mis;
        mis = (sz != 2'b00) && a[0];
        beats = (sz == 2'b00) ? 1 : nar ? nbytes(sz) : nbytes(sz) / 2;
        @(negedge clk);
        check("R1", "ready when idle", 32'(req_ready), 32'd1);
        req_valid = 1'b1; req_addr = a; req_size = sz; req_we = we;
        req_narrow = nar; req_wdata = wd; cur_narrow = nar;
        @(negedge clk);
        req_valid = 1'b0;
        if (mis) begin
            check("R8", "align_err", 32'(align_err), 32'd1);
            check("R8", "no bus cycle", 32'(bus_cyc), 32'd0);
            @(negedge clk);
            check("R8", "err single pulse", 32'(align_err), 32'd0);
            check("R8", "no done", {31'd0, done | bus_cyc}, 32'd0);
            return;
        end
        for (int i = 0; i < beats; i++) begin
            logic [AW-1:0] ea;
            logic eu, el;
            logic [15:0] ed;
            check("R1", "ready low in cycle", 32'(req_ready), 32'd0);
            check("R10", "bus_cyc/we", {30'd0, bus_cyc, bus_we}, {30'd0, 1'b1, we});
            if (nar) begin
                ea = a + AW'(i); eu = 1'b1; el = 1'b0;
                ed = {wbyte(wd, sz, i), 8'h00};
                check("R2", "narrow lanes", {30'd0, bus_ub, bus_lb}, {30'd0, eu, el});
                check("R3", "narrow addr", 32'(bus_addr), 32'(ea));
            end else if (sz == 2'b00) begin
                ea = a; eu = !a[0]; el = a[0];
                ed = a[0] ? {8'h00, wbyte(wd, sz, 0)} : {wbyte(wd, sz, 0), 8'h00};
                check("R4", "byte lanes", {30'd0, bus_ub, bus_lb}, {30'd0, eu, el});
                check("R4", "byte addr", 32'(bus_addr), 32'(ea));
            end else begin
                ea = a + AW'(2 * i); eu = 1'b1; el = 1'b1;
                ed = {wbyte(wd, sz, 2 * i), wbyte(wd, sz, 2 * i + 1)};
                check("R5", "word lanes", {30'd0, bus_ub, bus_lb}, {30'd0, eu, el});
                check("R5", "word addr", 32'(bus_addr), 32'(ea));
            end
            if (we) check("R6", "write lanes", 32'(bus_dout), 32'(ed));
            else    check("R10", "read dout quiet", 32'(bus_dout), 32'd0);
            @(negedge clk);
        end
        check("R9", "done after last", {31'd0, done}, 32'd1);
        check("R10", "idle lanes", {13'd0, bus_cyc, bus_ub, bus_lb, bus_dout}, 32'd0);
        if (!we) check("R7", "assembled rdata", rdata, exp_read(a, sz));
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #2000000;
        failures++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10", "reset quiet", {12'd0, bus_cyc, bus_ub, bus_lb, done, bus_dout}, 32'd0);
        check("R1", "reset ready", {30'd0, req_ready, align_err}, 32'd2);

        // Directed: every size in both spaces, both directions.
        for (int n = 0; n < 2; n++)
            for (int s = 0; s < 3; s++)
                for (int w = 0; w < 2; w++)
                    xfer(16'h1240, 2'(s), w[0], n[0], 32'hA1B2C3D4);
        xfer(16'h0033, 2'b00, 1'b1, 1'b0, 32'h0000005E);   // R4 odd byte, lower lane
        xfer(16'h0033, 2'b00, 1'b0, 1'b0, 32'h0);
        xfer(16'h0033, 2'b00, 1'b1, 1'b1, 32'h0000007C);   // R2 odd byte stays upper
        xfer(16'h0101, 2'b01, 1'b1, 1'b0, 32'h1234);       // R8 misaligned word
        xfer(16'h0207, 2'b10, 1'b0, 1'b1, 32'h0);          // R8 misaligned longword
        xfer(16'hFFFE, 2'b10, 1'b0, 1'b1, 32'h0);          // R3 address wrap
        xfer(16'hFFFE, 2'b10, 1'b1, 1'b0, 32'hDEADBEEF);   // R5 address wrap

        // Random transfers with occasional misaligned requests.
        for (int t = 0; t < 400; t++) begin
            logic [1:0] sz;
            logic [AW-1:0] a;
            sz = 2'($urandom_range(0, 2));
            a = AW'($urandom);
            if (sz != 2'b00 && ($urandom_range(0, 7) != 0)) a[0] = 1'b0;
            xfer(a, sz, 1'($urandom), 1'($urandom), $urandom);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule